// File: doc/BRIEF.md
# Serial Debug Scan Port

This block lets an external debug controller reach a bank of internal registers over a few serial wires. The controller supplies a slow shift clock, a serial input bit and three qualifiers: address mode, execute request and chip select. Each rising shift-clock edge does exactly one of three things: it shifts one bit into the component-address register, shifts the register that the address selects by one bit, or issues an execute strobe. Address shifting works whether or not the chip is selected. Data shifting and execute take effect only while the chip is selected. A separate debug reset input clears the whole port.

Every input is brought into the system clock domain through two-flop synchronizers. Rising shift-clock edges are found by oversampling, so all state lives in one clock domain. The shift clock therefore has to stay at least several system clocks high and several low. The serial output has an enable that is high only while the chip is selected, so an external pad can leave the line floating otherwise. Reading a register by feeding the serial output back into the serial input for a full register length leaves the register as it was. An execute edge produces a single-cycle strobe that the register owners can act on, together with the current address.

Top module: `dbg_scan_port`

## Requirements
- R1: While the synchronized debug reset is active, and on the first cycle after it ends, every scan register and the address register read zero, `exec_pulse` is low and `ser_out_en` is low.
- R2: A shift edge with `addr_mode` high and `exec_req` low shifts `ser_in` into bit 0 of the address register and moves the older bits up (the address is entered MSB first). This happens with `chip_sel` high or low, and no scan register changes.
- R3: A shift edge with `chip_sel` high and `addr_mode` and `exec_req` low shifts the selected register right by one bit and loads `ser_in` into its MSB. Register g is visible on `scan_regs[g*REG_W +: REG_W]`.
- R4: `ser_out_en` follows the synchronized `chip_sel`. While it is high, `ser_out` carries bit 0 of the selected register. While it is low, `ser_out` is 0.
- R5: With `chip_sel` low, data edges and execute edges change no register, leave the address unchanged and produce no strobe.
- R6: With `chip_sel` high, each execute edge produces exactly one `exec_pulse` that is one system clock long, and no register or address bit changes on that edge.
- R7: When `exec_req` and `addr_mode` are both high on one edge, the edge is an execute cycle and the address does not shift.
- R8: Addresses of NREG or above select no register: data edges change nothing and `ser_out` reads 0.
- R9: Shifting a register REG_W times, with `ser_out` fed back into `ser_in`, reads out its bits LSB first and leaves its contents unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| dbg_reset | input | 1 | Asynchronous debug reset, active high, synchronized inside |
| shift_clk | input | 1 | Debug shift clock; rising edges are sampled |
| addr_mode | input | 1 | Edge shifts an address bit |
| exec_req | input | 1 | Edge is an execute cycle (wins over addr_mode) |
| chip_sel | input | 1 | Enables data shifting, execute and serial output |
| ser_in | input | 1 | Serial data/address input |
| ser_out | output | 1 | Serial output, LSB of the selected register |
| ser_out_en | output | 1 | Drive enable for the serial output pad |
| cur_addr | output | ADDR_W | Current component address |
| exec_pulse | output | 1 | One-cycle execute strobe |
| scan_regs | output | NREG*REG_W | Contents of all scan registers |

## Verification
A wrong decode or priority shows on `cur_addr` or `scan_regs` within about five system clocks of the shift edge that went wrong, because the edge is synchronized, decoded and applied in a fixed, short pipeline. A bad select gate or mux shows on `ser_out` before the next shift edge, since the bench compares every bit it reads back against an arithmetic model. Missed or doubled execute cycles show as a mismatch between the count of strobes and the count of selected execute edges. An unmapped address that leaks shows as a register that changes when it should not.

// File: rtl/dbg_scan_pkg.sv
package dbg_scan_pkg;
  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_ADDR = 2'd1,
    OP_DATA = 2'd2,
    OP_EXEC = 2'd3
  } scan_op_e;
endpackage

// File: rtl/dbg_sync.sv
// Multi-stage synchronizer with a power-up value held in the flops.
module dbg_sync #(
  parameter int          W        = 1,
  parameter int          STAGES   = 2,
  parameter logic [W-1:0] INIT_VAL = '0
) (
  input  logic         clk,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  localparam int CHAIN_W = STAGES * W;

  logic [CHAIN_W-1:0] chain = {STAGES{INIT_VAL}};

  always_ff @(posedge clk) begin
    chain <= CHAIN_W'({chain, d});
  end

  assign q = chain[CHAIN_W-1 -: W];
endmodule

// File: rtl/dbg_edge_ctrl.sv
// Finds rising shift-clock edges and decodes the operation for each one.
module dbg_edge_ctrl
  import dbg_scan_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     sck_s,
  input  logic     addr_s,
  input  logic     exec_s,
  input  logic     sel_s,
  input  logic     sdi_s,
  output scan_op_e op_q,
  output logic     sdi_q,
  output logic     exec_pulse
);
  logic     sck_d;
  logic     rise;
  scan_op_e op_nx;

  assign rise = sck_s & ~sck_d;

  // execute wins over address; data and execute need select
  always_comb begin
    if (exec_s)      op_nx = sel_s ? OP_EXEC : OP_NONE;
    else if (addr_s) op_nx = OP_ADDR;
    else if (sel_s)  op_nx = OP_DATA;
    else             op_nx = OP_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_d      <= sck_s;
      op_q       <= OP_NONE;
      sdi_q      <= 1'b0;
      exec_pulse <= 1'b0;
    end else begin
      sck_d      <= sck_s;
      op_q       <= rise ? op_nx : OP_NONE;
      if (rise) sdi_q <= sdi_s;
      exec_pulse <= (op_q == OP_EXEC);
    end
  end
endmodule

// File: rtl/dbg_addr_reg.sv
// Component-address shift register, MSB entered first.
module dbg_addr_reg
  import dbg_scan_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  scan_op_e          op,
  input  logic              sdi,
  output logic [ADDR_W-1:0] addr_q
);
  always_ff @(posedge clk) begin
    if (rst)                addr_q <= '0;
    else if (op == OP_ADDR) addr_q <= ADDR_W'({addr_q, sdi});
  end
endmodule

// File: rtl/dbg_scan_bank.sv
// Bank of scan registers; the addressed one shifts right, input at MSB.
module dbg_scan_bank
  import dbg_scan_pkg::*;
#(
  parameter int NREG   = 3,
  parameter int REG_W  = 8,
  parameter int ADDR_W = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  scan_op_e              op,
  input  logic                  sdi,
  input  logic [ADDR_W-1:0]     addr,
  input  logic                  sel,
  output logic [NREG*REG_W-1:0] regs_flat,
  output logic                  dso,
  output logic                  dso_en
);
  logic [REG_W-1:0] regs [NREG];
  logic             lsb_mux;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)
        regs[g] <= '0;
      else if (op == OP_DATA && addr == ADDR_W'(g))
        regs[g] <= REG_W'({sdi, regs[g]} >> 1);
    end
    assign regs_flat[g*REG_W +: REG_W] = regs[g];
  end

  always_comb begin
    lsb_mux = 1'b0;
    for (int i = 0; i < NREG; i++)
      if (addr == ADDR_W'(i)) lsb_mux = regs[i][0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dso    <= 1'b0;
      dso_en <= 1'b0;
    end else begin
      dso    <= sel & lsb_mux;
      dso_en <= sel;
    end
  end
endmodule

// File: rtl/dbg_scan_port.sv
module dbg_scan_port
  import dbg_scan_pkg::*;
#(
  parameter int NREG        = 3,
  parameter int ADDR_W      = 2,
  parameter int REG_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  dbg_reset,
  input  logic                  shift_clk,
  input  logic                  addr_mode,
  input  logic                  exec_req,
  input  logic                  chip_sel,
  input  logic                  ser_in,
  output logic                  ser_out,
  output logic                  ser_out_en,
  output logic [ADDR_W-1:0]     cur_addr,
  output logic                  exec_pulse,
  output logic [NREG*REG_W-1:0] scan_regs
);
  localparam int IN_W = 5;

  logic            rst_s;
  logic [IN_W-1:0] in_s;
  logic            sck_s, addr_s, exec_s, sel_s, sdi_s;
  scan_op_e        op_q;
  logic            sdi_q;

  dbg_sync #(.W(1), .STAGES(SYNC_STAGES), .INIT_VAL(1'b1)) u_rst_sync (
    .clk (clk),
    .d   (dbg_reset),
    .q   (rst_s)
  );

  dbg_sync #(.W(IN_W), .STAGES(SYNC_STAGES), .INIT_VAL('0)) u_in_sync (
    .clk (clk),
    .d   ({shift_clk, addr_mode, exec_req, chip_sel, ser_in}),
    .q   (in_s)
  );

  assign {sck_s, addr_s, exec_s, sel_s, sdi_s} = in_s;

  dbg_edge_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst_s),
    .sck_s      (sck_s),
    .addr_s     (addr_s),
    .exec_s     (exec_s),
    .sel_s      (sel_s),
    .sdi_s      (sdi_s),
    .op_q       (op_q),
    .sdi_q      (sdi_q),
    .exec_pulse (exec_pulse)
  );

  dbg_addr_reg #(.ADDR_W(ADDR_W)) u_addr (
    .clk    (clk),
    .rst    (rst_s),
    .op     (op_q),
    .sdi    (sdi_q),
    .addr_q (cur_addr)
  );

  dbg_scan_bank #(.NREG(NREG), .REG_W(REG_W), .ADDR_W(ADDR_W)) u_bank (
    .clk       (clk),
    .rst       (rst_s),
    .op        (op_q),
    .sdi       (sdi_q),
    .addr      (cur_addr),
    .sel       (sel_s),
    .regs_flat (scan_regs),
    .dso       (ser_out),
    .dso_en    (ser_out_en)
  );
endmodule

// File: rtl/dbg_scan_chk.sv
module dbg_scan_chk #(
  parameter int NREG   = 3,
  parameter int ADDR_W = 2,
  parameter int REG_W  = 8
) (
  input logic                  clk,
  input logic                  rst_s,
  input logic                  sel_s,
  input logic                  ser_out,
  input logic                  ser_out_en,
  input logic [ADDR_W-1:0]     cur_addr,
  input logic                  exec_pulse,
  input logic [NREG*REG_W-1:0] scan_regs
);
  AST_RESET_CLEAR: assert property (@(posedge clk)
    $fell(rst_s) |-> (scan_regs == '0 && cur_addr == '0 && !exec_pulse && !ser_out_en)); // R1

  AST_ADDR_ONLY: assert property (@(posedge clk) disable iff (rst_s)
    !$stable(cur_addr) |-> $stable(scan_regs)); // R2

  AST_OUT_QUIET: assert property (@(posedge clk) disable iff (rst_s)
    !ser_out_en |-> !ser_out); // R4

  AST_EXEC_NEEDS_SEL: assert property (@(posedge clk) disable iff (rst_s)
    exec_pulse |-> $past(sel_s, 2)); // R5

  AST_EXEC_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst_s)
    exec_pulse |=> !exec_pulse); // R6

  AST_EXEC_NO_SHIFT: assert property (@(posedge clk) disable iff (rst_s)
    exec_pulse |-> ($stable(scan_regs) && $stable(cur_addr))); // R6 R7

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst_s)
    (int'($past(cur_addr)) >= NREG) |-> !ser_out); // R8
endmodule

bind dbg_scan_port dbg_scan_chk #(.NREG(NREG), .ADDR_W(ADDR_W), .REG_W(REG_W)) u_chk (
  .clk        (clk),
  .rst_s      (rst_s),
  .sel_s      (sel_s),
  .ser_out    (ser_out),
  .ser_out_en (ser_out_en),
  .cur_addr   (cur_addr),
  .exec_pulse (exec_pulse),
  .scan_regs  (scan_regs)
);

// File: tb/sim_dbg_scan_port.sv
module sim_dbg_scan_port;
  localparam int NREG = 3;
  localparam int AW   = 2;
  localparam int W    = 8;

  logic clk = 1'b0;
  logic dbg_reset = 1'b1;
  logic shift_clk = 1'b0, addr_mode = 1'b0, exec_req = 1'b0, chip_sel = 1'b0, ser_in = 1'b0;
  logic ser_out, ser_out_en, exec_pulse;
  logic [AW-1:0] cur_addr;
  logic [NREG*W-1:0] scan_regs;

  always #4 clk = ~clk;

  dbg_scan_port #(.NREG(NREG), .ADDR_W(AW), .REG_W(W)) u0 (
    .clk(clk), .dbg_reset(dbg_reset), .shift_clk(shift_clk), .addr_mode(addr_mode),
    .exec_req(exec_req), .chip_sel(chip_sel), .ser_in(ser_in), .ser_out(ser_out),
    .ser_out_en(ser_out_en), .cur_addr(cur_addr), .exec_pulse(exec_pulse),
    .scan_regs(scan_regs)
  );

  int checks = 0, errors = 0;
  int pulse_cnt = 0, wide_pulses = 0, exp_exec = 0;
  logic prev_pulse = 1'b0;
  logic [W-1:0]  exp_regs [NREG];
  logic [AW-1:0] exp_addr;

  always @(posedge clk) begin
    if (exec_pulse) pulse_cnt++;
    if (exec_pulse && prev_pulse) wide_pulses++;
    prev_pulse = exec_pulse;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int g = 0; g < NREG; g++) exp_regs[g] = '0;
    exp_addr = '0;
  endtask

  // one shift-clock period; the model is updated with the same operation
  task automatic shift_edge(input logic a, input logic e, input logic s, input logic d);
    if (e) begin
      if (s) exp_exec++;
    end else if (a) begin
      exp_addr = AW'({exp_addr, d});
    end else if (s && int'(exp_addr) < NREG) begin
      exp_regs[exp_addr] = W'({d, exp_regs[exp_addr]} >> 1);
    end
    @(negedge clk);
    addr_mode = a; exec_req = e; chip_sel = s; ser_in = d;
    repeat (4) @(negedge clk);
    shift_clk = 1'b1;
    repeat (6) @(negedge clk);
    shift_clk = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic check_state(input string req);
    logic [NREG*W-1:0] ef;
    logic exp_so;
    for (int g = 0; g < NREG; g++) ef[g*W +: W] = exp_regs[g];
    exp_so = chip_sel && int'(exp_addr) < NREG && exp_regs[exp_addr][0];
    chk(scan_regs == ef, req, "scan_regs", 64'(scan_regs), 64'(ef));
    chk(cur_addr == exp_addr, req, "cur_addr", 64'(cur_addr), 64'(exp_addr));
    chk(ser_out_en == chip_sel, req, "ser_out_en", 64'(ser_out_en), 64'(chip_sel));
    chk(ser_out == exp_so, req, "ser_out", 64'(ser_out), 64'(exp_so));
    chk(pulse_cnt == exp_exec, req, "exec count", 64'(pulse_cnt), 64'(exp_exec));
  endtask

  task automatic load_addr(input int a, input logic s);
    shift_edge(1'b1, 1'b0, s, a[1]);
    shift_edge(1'b1, 1'b0, s, a[0]);
  endtask

  task automatic do_reset();
    @(negedge clk);
    dbg_reset = 1'b1;
    repeat (8) @(negedge clk);
    dbg_reset = 1'b0;
    model_reset();
    repeat (4) @(negedge clk);
  endtask

  bit done = 1'b0;

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] pat;
    logic bit_rd;
    do_reset();
    check_state("R1");

    // R2: address sweep with select low and high
    for (int a = 0; a < 4; a++) begin
      for (int s = 0; s < 2; s++) begin
        load_addr(a, s[0]);
        check_state("R2");
      end
    end

    // R3/R8 write, then R4/R9 read-restore, for every address
    for (int a = 0; a < 4; a++) begin
      load_addr(a, a[0]);
      pat = W'(a * 8'h5b + 8'h3c);
      for (int b = 0; b < W; b++) shift_edge(1'b0, 1'b0, 1'b1, pat[b]);
      check_state(a < NREG ? "R3" : "R8");
      for (int b = 0; b < W; b++) begin
        bit_rd = ser_out;
        chk(bit_rd == ((a < NREG) ? pat[b] : 1'b0), "R4 R9", "read bit",
            64'(bit_rd), 64'((a < NREG) ? pat[b] : 1'b0));
        shift_edge(1'b0, 1'b0, 1'b1, bit_rd);
      end
      check_state("R9");
    end

    // R5: data edges without select change nothing
    load_addr(1, 1'b0);
    for (int b = 0; b < W; b++) shift_edge(1'b0, 1'b0, 1'b0, 1'b1);
    check_state("R5");

    // R6: selected execute edges
    for (int k = 0; k < 3; k++) shift_edge(1'b0, 1'b1, 1'b1, k[0]);
    check_state("R6");
    // R7: execute beats address
    shift_edge(1'b1, 1'b1, 1'b1, 1'b1);
    check_state("R7");
    // R5: unselected execute, also with address high
    shift_edge(1'b0, 1'b1, 1'b0, 1'b0);
    shift_edge(1'b1, 1'b1, 1'b0, 1'b1);
    check_state("R5");
    chk(wide_pulses == 0, "R6", "wide pulses", 64'(wide_pulses), 64'd0);

    // R1: reset after activity
    do_reset();
    check_state("R1");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule